// File: doc/BRIEF.md
# Receive Packet Length Monitor

This block watches a wide receive stream that carries no backpressure. The stream has a 256-bit data bus, so each beat holds 32 bytes. The monitor only observes, so it needs the control signals and not the data bus. These are a valid qualifier, start and end markers, and a 5-bit count of unused bytes on the final beat. For each packet it adds up the payload bytes and reports the total with a one-cycle completion strobe. It also flags framing mistakes: a start marker while a packet is still open, or a beat that belongs to no packet.

The source may drop valid in the middle of a packet and leave stale values on the bus. The monitor therefore counts only cycles where valid is high. It ignores every other receive input on cycles where valid is low, and it takes the empty count into account only on the closing beat. Payload content, CRC and addressing are not examined.

Top module: `rx_len_mon`

## Requirements
- R1: After a synchronous active-high reset, `pkt_len` is 0, and `pkt_done`, `err_dup_sop` and `err_orphan` are all low.
- R2: A packet of N accepted beats reports a length of 32·N minus the empty value sampled on its end beat.
- R3: On a cycle with `in_valid` low, `in_sop`, `in_eop` and `in_empty` have no effect. Such gaps inside a packet leave the reported length unchanged, and produce no strobe or flag in the following cycle.
- R4: A beat with `in_sop` and `in_eop` both high is a complete single-beat packet, with length 32 minus `in_empty`.
- R5: `in_empty` is ignored on every beat where `in_eop` is low.
- R6: `pkt_done` is high for exactly the one cycle after each accepted end beat. `pkt_len` is updated in that same cycle and holds its value until the next `pkt_done`.
- R7: A valid start beat while a packet is already open raises `err_dup_sop` in the next cycle. The bytes of the open packet are discarded, and counting restarts with that start beat.
- R8: A valid beat with `in_sop` low while no packet is open raises `err_orphan` in the next cycle. This includes an end beat. The beat is not counted, `pkt_done` stays low and `pkt_len` is unchanged.
- R9: An end beat followed immediately by a start beat gives two separate results on consecutive cycles, each with its own length.
- R10: `in_empty` is a plain binary count from 0 to 31 of unused bytes at the least significant end of the end beat. A value of 0 means the whole beat is used, and 31 leaves one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier; all other inputs are ignored while low |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 5 | Unused bytes in the last beat |
| pkt_len | output | 16 | Byte length of the most recently completed packet |
| pkt_done | output | 1 | One-cycle strobe when `pkt_len` is updated |
| err_dup_sop | output | 1 | Pulse: start beat arrived while a packet was open |
| err_orphan | output | 1 | Pulse: valid beat arrived with no packet open |

## Verification
The hardest case to create from the ports is a gap in the middle of a packet while the stale control lines look like a new start and an end. The bench builds it by holding `in_sop` and `in_eop` high, with a different `in_empty`, during cycles where `in_valid` is low, inside an open packet. It checks that no strobe appears during the gap and that the final length counts only the qualified beats. A second hard case is a start beat that lands inside an open packet. The bench first accumulates bytes that must then be discarded, so a wrong length reveals any leftover count.

// File: rtl/rx_len_mon.sv
module rx_len_mon #(
  parameter int BEAT_BYTES = 32,
  parameter int EMPTY_W    = 5,
  parameter int LEN_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  output logic [LEN_W-1:0]   pkt_len,
  output logic               pkt_done,
  output logic               err_dup_sop,
  output logic               err_orphan
);

  localparam logic [LEN_W-1:0] BEAT = LEN_W'(BEAT_BYTES);

  logic             open_q;
  logic [LEN_W-1:0] acc_q;
  logic             take;
  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] trim;
  logic [LEN_W-1:0] total;

  assign take  = in_valid & (in_sop | open_q);
  assign base  = in_sop ? '0 : acc_q;
  assign trim  = in_eop ? LEN_W'(in_empty) : '0;
  assign total = base + BEAT - trim;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      acc_q       <= '0;
      pkt_len     <= '0;
      pkt_done    <= 1'b0;
      err_dup_sop <= 1'b0;
      err_orphan  <= 1'b0;
    end else begin
      pkt_done    <= take & in_eop;
      err_dup_sop <= in_valid & in_sop & open_q;
      err_orphan  <= in_valid & ~in_sop & ~open_q;
      if (take) begin
        if (in_eop) begin
          pkt_len <= total;
          acc_q   <= '0;
          open_q  <= 1'b0;
        end else begin
          acc_q   <= total;
          open_q  <= 1'b1;
        end
      end
    end
  end

  assert_quiet_gap_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !pkt_done && !err_dup_sop && !err_orphan);

  assert_single_beat_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sop && in_eop |=> pkt_done && pkt_len == BEAT - LEN_W'($past(in_empty)));

  assert_done_after_eop_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> $past(in_valid && in_eop));

  assert_len_held_R6: assert property (@(posedge clk) disable iff (rst)
    !pkt_done |-> $stable(pkt_len));

  assert_orphan_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    err_orphan |-> !pkt_done && !err_dup_sop);

endmodule

// File: tb/rx_len_mon_tb.sv
module rx_len_mon_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [4:0]  in_empty = '0;
  logic [15:0] pkt_len;
  logic        pkt_done, err_dup_sop, err_orphan;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_len_mon u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .pkt_len(pkt_len), .pkt_done(pkt_done),
    .err_dup_sop(err_dup_sop), .err_orphan(err_orphan));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic e, input logic [4:0] emp);
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; in_empty = emp;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 len", pkt_len, 0);
    chk("R1 done", pkt_done, 0);
    chk("R1 flags", {err_dup_sop, err_orphan}, 0);
    rst = 1'b0;
    idle();
  endtask

  task automatic t_multi();
    drive(1, 1, 0, 5'd9);
    drive(1, 0, 0, 5'd0);
    drive(1, 0, 1, 5'd2);
    idle();
    chk("R2 done 3 beats", pkt_done, 1);
    chk("R2 R10 len 3 beats empty 2", pkt_len, 94);
    drive(1, 1, 0, 0); drive(1, 0, 0, 0); drive(1, 0, 0, 0); drive(1, 0, 1, 0);
    idle();
    chk("R2 R10 len 4 beats empty 0", pkt_len, 128);
  endtask

  task automatic t_gaps();
    drive(1, 1, 0, 0);
    drive(0, 1, 1, 5'd7);
    idle();
    chk("R3 no done after stale gap", pkt_done, 0);
    chk("R3 no flag after stale gap", {err_dup_sop, err_orphan}, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 5'd3);
    drive(0, 1, 0, 5'd3);
    drive(1, 0, 1, 5'd5);
    idle();
    chk("R3 done after gapped packet", pkt_done, 1);
    chk("R3 len with gaps", pkt_len, 91);
  endtask

  task automatic t_single();
    drive(1, 1, 1, 5'd31);
    idle();
    chk("R4 done single", pkt_done, 1);
    chk("R4 R10 len empty 31", pkt_len, 1);
    drive(1, 1, 1, 5'd0);
    idle();
    chk("R4 R10 len empty 0", pkt_len, 32);
  endtask

  task automatic t_empty_mid();
    drive(1, 1, 0, 5'd17);
    drive(1, 0, 0, 5'd29);
    drive(1, 0, 1, 5'd0);
    idle();
    chk("R5 mid-beat empty ignored", pkt_len, 96);
  endtask

  task automatic t_done_pulse();
    drive(1, 1, 0, 0);
    drive(1, 0, 1, 5'd8);
    idle();
    chk("R6 done set", pkt_done, 1);
    chk("R6 len", pkt_len, 56);
    idle();
    chk("R6 done one cycle", pkt_done, 0);
    chk("R6 len held", pkt_len, 56);
  endtask

  task automatic t_dup_sop();
    drive(1, 1, 0, 0);
    drive(1, 0, 0, 0);
    drive(1, 1, 0, 0);
    drive(1, 0, 1, 5'd0);
    chk("R7 dup sop flag", err_dup_sop, 1);
    chk("R7 no done on dup", pkt_done, 0);
    idle();
    chk("R7 flag one cycle", err_dup_sop, 0);
    chk("R7 restart count", pkt_len, 64);
  endtask

  task automatic t_orphan();
    drive(1, 0, 1, 5'd4);
    idle();
    chk("R8 orphan flag", err_orphan, 1);
    chk("R8 no done", pkt_done, 0);
    chk("R8 len unchanged", pkt_len, 64);
    drive(1, 0, 0, 0);
    idle();
    chk("R8 orphan mid flag", err_orphan, 1);
    idle();
    chk("R8 flag clears", err_orphan, 0);
  endtask

  task automatic t_b2b();
    drive(1, 1, 0, 0);
    drive(1, 0, 1, 5'd4);
    drive(1, 1, 1, 5'd0);
    chk("R9 first done", pkt_done, 1);
    chk("R9 first len", pkt_len, 60);
    idle();
    chk("R9 second done", pkt_done, 1);
    chk("R9 second len", pkt_len, 32);
    chk("R9 no flags", {err_dup_sop, err_orphan}, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_multi();
    t_gaps();
    t_single();
    t_empty_mid();
    t_done_pulse();
    t_dup_sop();
    t_orphan();
    t_b2b();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule